// File: doc/BRIEF.md
# Mode-Configurable Distributed Lookup RAM

This block is a small on-chip memory made from two 16-entry, 1-bit storage arrays that share one set of control pins. A static organisation input decides how those pins are mapped onto the two arrays: two separate 16x1 memories with a data bit each, one 32x1 memory, or one 16x1 memory with a single write port and two independent read ports.

Writes are synchronous: on the rising clock edge, and only when write enable is high, the addressed cell or cells take the write data. Reads are combinational and work the same way in every organisation. Each of the two read outputs can be taken straight from the read path or from a flop that samples the read path on every rising edge. A synchronous active-high reset clears every cell and both output flops.

Top module: `lutram_cfg`

## Requirements
- R1: While `rst` is high at a rising edge, every cell of both arrays and both output flops become 0, so the first read after reset returns 0 on both outputs.
- R2: With `cfg_mode` = 0 (split), `dout0` reads array A at `addr_a` and `dout1` reads array B at `addr_b`; a write stores `din0` into A at `addr_a` and `din1` into B at `addr_b`.
- R3: With `cfg_mode` = 1 (wide), the 5-bit address is {`din1`, `addr_a`}; `din1` = 0 selects array A and 1 selects array B, a write stores `din0` only into the selected array, `dout0` shows the selected cell and the unregistered `dout1` is 0.
- R4: Contents change only at a rising edge with `we` high; with `we` low the data and address inputs leave every cell unchanged.
- R5: With `cfg_mode` = 2 (dual-port), a write stores `din0` at `addr_a` into both arrays; `dout0` reads `addr_a` and `dout1` reads `addr_b` independently.
- R6: When a read and a write hit the same address in one cycle, the combinational output shows the old data before the edge and the new data after it.
- R7: When `out_reg_en[i]` is 1, `dout<i>` shows the combinational read value sampled at the previous rising edge; when 0, it shows the combinational read value directly.
- R8: `cfg_mode` = 3 behaves exactly as the split organisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and output flops act on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Static organisation select: 0 split, 1 wide, 2 dual-port, 3 split |
| out_reg_en | input | 2 | Per-output select of the registered read path (bit 0 for dout0) |
| we | input | 1 | Write enable, sampled at the rising edge |
| addr_a | input | 4 | Address of array A; write address in wide and dual-port modes |
| addr_b | input | 4 | Address of array B; read-only address in dual-port mode |
| din0 | input | 1 | Write data for array A, or for the whole memory in wide and dual-port modes |
| din1 | input | 1 | Write data for array B in split mode; fifth address bit in wide mode |
| dout0 | output | 1 | First read output |
| dout1 | output | 1 | Second read output |

## Verification
The assertions take the organisation input as fixed between resets: the check that both dual-port read outputs agree on a shared address only holds if both arrays have been written together since the last reset. The stimulus therefore changes `cfg_mode` and `out_reg_en` only while `rst` is high, and drives every other input half a period away from the rising edge. A reference model in the bench tracks both arrays and both output flops so that same-address read-during-write cycles and registered outputs are predicted from the requirements alone.

// File: rtl/lutram_pkg.sv
package lutram_pkg;

    localparam int LR_AW    = 4;
    localparam int LR_DEPTH = 1 << LR_AW;
    localparam int LR_NOUT  = 2;

    typedef enum logic [1:0] {
        ORG_SPLIT = 2'd0,
        ORG_WIDE  = 2'd1,
        ORG_DUAL  = 2'd2,
        ORG_ALT   = 2'd3
    } org_e;

    // Write request for one array
    typedef struct packed {
        logic             en;
        logic [LR_AW-1:0] addr;
        logic             data;
    } wr_req_t;

    function automatic logic org_is_wide(org_e m);
        return m == ORG_WIDE;
    endfunction

    function automatic logic org_is_dual(org_e m);
        return m == ORG_DUAL;
    endfunction

endpackage

// File: rtl/lr_cell_array.sv
module lr_cell_array
    import lutram_pkg::*;
#(
    parameter int AW = LR_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_req_t       wr,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DEPTH-1:0] mem;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= '0;
        end else if (wr.en) begin
            mem[wr.addr[AW-1:0]] <= wr.data;
        end
    end

    assign rd_data = mem[rd_addr];

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> mem == '0); // R1

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr.en |=> mem[$past(wr.addr[AW-1:0])] == $past(wr.data)); // R4

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !wr.en |=> $stable(mem)); // R4

endmodule

// File: rtl/lr_wr_route.sv
module lr_wr_route
    import lutram_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  org_e             org,
    input  logic             we,
    input  logic [LR_AW-1:0] addr_a,
    input  logic [LR_AW-1:0] addr_b,
    input  logic             din0,
    input  logic             din1,
    output wr_req_t          wr_a,
    output wr_req_t          wr_b
);
    always_comb begin
        wr_a = '{en: we, addr: addr_a, data: din0};
        wr_b = '{en: we, addr: addr_b, data: din1};
        if (org_is_wide(org)) begin
            // din1 is the top address bit
            wr_a.en   = we & ~din1;
            wr_b.en   = we & din1;
            wr_b.addr = addr_a;
            wr_b.data = din0;
        end else if (org_is_dual(org)) begin
            // shared write into both arrays
            wr_b.addr = addr_a;
            wr_b.data = din0;
        end
    end

    AST_WIDE_ONE_BANK: assert property (@(posedge clk) disable iff (rst)
        (org == ORG_WIDE) |-> !(wr_a.en && wr_b.en)); // R3

    AST_DUAL_SAME_CELL: assert property (@(posedge clk) disable iff (rst)
        (org == ORG_DUAL && we) |-> (wr_a.addr == wr_b.addr && wr_a.data == wr_b.data)); // R5

endmodule

// File: rtl/lr_rd_route.sv
module lr_rd_route
    import lutram_pkg::*;
(
    input  org_e             org,
    input  logic [LR_AW-1:0] addr_a,
    input  logic [LR_AW-1:0] addr_b,
    input  logic             din1,
    input  logic             cell_a,
    input  logic             cell_b,
    output logic [LR_AW-1:0] rd_addr_a,
    output logic [LR_AW-1:0] rd_addr_b,
    output logic             q0,
    output logic             q1
);
    always_comb begin
        rd_addr_a = addr_a;
        rd_addr_b = addr_b;
        q0        = cell_a;
        q1        = cell_b;
        if (org_is_wide(org)) begin
            rd_addr_b = addr_a;
            q0        = din1 ? cell_b : cell_a;
            q1        = 1'b0;
        end
    end
endmodule

// File: rtl/lr_out_stage.sv
module lr_out_stage #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sel,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] flop;

    for (genvar i = 0; i < N; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) flop[i] <= 1'b0;
            else     flop[i] <= d[i];
        end
        assign q[i] = sel[i] ? flop[i] : d[i];

        AST_REG_PATH: assert property (@(posedge clk) disable iff (rst)
            sel[i] |=> q[i] == $past(d[i])); // R7
    end
endmodule

// File: rtl/lutram_cfg.sv
module lutram_cfg
    import lutram_pkg::*;
#(
    parameter int AW   = LR_AW,
    parameter int NOUT = LR_NOUT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      cfg_mode,
    input  logic [NOUT-1:0] out_reg_en,
    input  logic            we,
    input  logic [AW-1:0]   addr_a,
    input  logic [AW-1:0]   addr_b,
    input  logic            din0,
    input  logic            din1,
    output logic            dout0,
    output logic            dout1
);
    org_e             org;
    wr_req_t          wr_a, wr_b;
    logic [AW-1:0]    rd_addr_a, rd_addr_b;
    logic             cell_a, cell_b;
    logic [NOUT-1:0]  comb_q, out_q;

    assign org = org_e'(cfg_mode);

    lr_wr_route u_wr (
        .clk(clk), .rst(rst), .org(org), .we(we),
        .addr_a(addr_a), .addr_b(addr_b), .din0(din0), .din1(din1),
        .wr_a(wr_a), .wr_b(wr_b)
    );

    lr_cell_array #(.AW(AW)) u_arr_a (
        .clk(clk), .rst(rst), .wr(wr_a), .rd_addr(rd_addr_a), .rd_data(cell_a)
    );

    lr_cell_array #(.AW(AW)) u_arr_b (
        .clk(clk), .rst(rst), .wr(wr_b), .rd_addr(rd_addr_b), .rd_data(cell_b)
    );

    lr_rd_route u_rd (
        .org(org), .addr_a(addr_a), .addr_b(addr_b), .din1(din1),
        .cell_a(cell_a), .cell_b(cell_b),
        .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
        .q0(comb_q[0]), .q1(comb_q[1])
    );

    lr_out_stage #(.N(NOUT)) u_out (
        .clk(clk), .rst(rst), .sel(out_reg_en), .d(comb_q), .q(out_q)
    );

    assign dout0 = out_q[0];
    assign dout1 = out_q[1];

    AST_WIDE_DOUT1_ZERO: assert property (@(posedge clk) disable iff (rst)
        (org == ORG_WIDE && !out_reg_en[1]) |-> dout1 == 1'b0); // R3

    AST_DUAL_MIRROR: assert property (@(posedge clk) disable iff (rst)
        (org == ORG_DUAL && addr_a == addr_b) |-> comb_q[0] == comb_q[1]); // R5

endmodule

// File: tb/sim_lutram_cfg.sv
module sim_lutram_cfg;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic  e0;
        logic  e1;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cfg_mode = 2'd0;
    logic [1:0] out_reg_en = 2'b00;
    logic       we = 1'b0;
    logic [3:0] addr_a = '0, addr_b = '0;
    logic       din0 = 1'b0, din1 = 1'b0;
    logic       dout0, dout1;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    exp_t sb_q[$];

    // reference model
    bit ma[16];
    bit mb[16];
    bit rm0, rm1;

    lutram_cfg u0 (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .out_reg_en(out_reg_en),
        .we(we), .addr_a(addr_a), .addr_b(addr_b), .din0(din0), .din1(din1),
        .dout0(dout0), .dout1(dout1)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic do_reset(input logic [1:0] m, input logic [1:0] re);
        @(negedge clk);
        rst = 1'b1; cfg_mode = m; out_reg_en = re; we = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 16; i++) begin ma[i] = 0; mb[i] = 0; end
        rm0 = 0; rm1 = 0;
    endtask

    // drive one cycle; push expected outputs for the scoreboard
    task automatic cyc(input logic w, input logic [3:0] aa, input logic [3:0] ab,
                       input logic d0, input logic d1, input string tag);
        bit c0, c1;
        exp_t it;
        if (rst) @(negedge clk);
        else if (sb_q.size() != 0 || n_checks != 0) @(negedge clk);
        we = w; addr_a = aa; addr_b = ab; din0 = d0; din1 = d1;
        if (cfg_mode == 2'd1) begin
            c0 = d1 ? mb[aa] : ma[aa];
            c1 = 0;
        end else begin
            c0 = ma[aa];
            c1 = mb[ab];
        end
        it.e0 = out_reg_en[0] ? rm0 : c0;
        it.e1 = out_reg_en[1] ? rm1 : c1;
        it.tag = tag;
        sb_q.push_back(it);
        rm0 = c0; rm1 = c1;
        if (w) begin
            case (cfg_mode)
                2'd1: if (d1) mb[aa] = d0; else ma[aa] = d0;
                2'd2: begin ma[aa] = d0; mb[aa] = d0; end
                default: begin ma[aa] = d0; mb[ab] = d1; end
            endcase
        end
    endtask

    // monitor: pops one expectation per cycle, samples mid low phase
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (sb_q.size() != 0) begin
                exp_t it;
                it = sb_q.pop_front();
                n_checks++;
                if (dout0 !== it.e0 || dout1 !== it.e1) begin
                    n_fail++;
                    $display("FAIL %s: dout0/dout1 = %b%b expected %b%b",
                             it.tag, dout0, dout1, it.e0, it.e1);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // split organisation, combinational outputs
        do_reset(2'd0, 2'b00);
        cyc(0, 4'd3, 4'd5, 0, 0, "R1");
        cyc(0, 4'd15, 4'd0, 1, 1, "R1");
        cyc(1, 4'd3, 4'd5, 1, 1, "R2");
        cyc(0, 4'd3, 4'd5, 0, 0, "R2");
        cyc(1, 4'd8, 4'd8, 1, 0, "R2");
        cyc(0, 4'd8, 4'd8, 0, 0, "R2");
        cyc(0, 4'd5, 4'd3, 0, 0, "R2");
        cyc(0, 4'd3, 4'd5, 0, 0, "R4");
        cyc(0, 4'd3, 4'd5, 0, 0, "R4");
        cyc(1, 4'd9, 4'd9, 1, 1, "R6");
        cyc(0, 4'd9, 4'd9, 0, 0, "R6");

        // mode 3 aliases split
        do_reset(2'd3, 2'b00);
        cyc(1, 4'd1, 4'd2, 1, 0, "R8");
        cyc(1, 4'd2, 4'd1, 0, 1, "R8");
        cyc(0, 4'd1, 4'd1, 0, 0, "R8");
        cyc(0, 4'd2, 4'd2, 0, 0, "R8");

        // wide organisation
        do_reset(2'd1, 2'b00);
        cyc(1, 4'd2, 4'd0, 1, 1, "R3");
        cyc(0, 4'd2, 4'd0, 0, 0, "R3");
        cyc(0, 4'd2, 4'd0, 0, 1, "R3");
        cyc(1, 4'd7, 4'd7, 1, 0, "R3");
        cyc(0, 4'd7, 4'd7, 0, 1, "R3");
        cyc(0, 4'd7, 4'd7, 0, 0, "R3");
        cyc(0, 4'd7, 4'd9, 1, 0, "R4");

        // dual-port organisation
        do_reset(2'd2, 2'b00);
        cyc(1, 4'd4, 4'd4, 1, 0, "R6");
        cyc(0, 4'd9, 4'd4, 0, 0, "R5");
        cyc(0, 4'd4, 4'd9, 0, 0, "R5");
        cyc(1, 4'd11, 4'd2, 1, 0, "R5");
        cyc(0, 4'd2, 4'd11, 0, 0, "R5");

        // dual-port with both outputs registered
        do_reset(2'd2, 2'b11);
        cyc(1, 4'd6, 4'd6, 1, 0, "R7");
        cyc(0, 4'd6, 4'd6, 0, 0, "R7");
        cyc(0, 4'd6, 4'd6, 0, 0, "R7");

        // split, output 0 registered, random traffic
        do_reset(2'd0, 2'b01);
        for (int k = 0; k < 60; k++) begin
            cyc(1'($urandom), 4'($urandom), 4'($urandom),
                1'($urandom), 1'($urandom), "R7");
        end

        // wide, output 1 registered, random traffic
        do_reset(2'd1, 2'b10);
        for (int k = 0; k < 60; k++) begin
            cyc(1'($urandom), 4'($urandom), 4'($urandom),
                1'($urandom), 1'($urandom), "R3");
        end

        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule